// File: doc/BRIEF.md
# DMA Descriptor Configuration Error Checker

This block sits next to a DMA channel engine. It checks the transfer descriptor of a channel at the moment that channel is activated. It also checks the scatter/gather link address when a major loop completes, and it turns bus error strobes from the read and write sides into recorded errors. The block keeps one 32-bit status word that holds the latest failure only. That word gives the failing channel number and one flag for each class of failure.

Each failure pulses an abort toward the engine for one cycle and sets the channel's bit in a per-channel error vector. The vector stays set until a write-one-to-clear input clears it. A summary valid output is high while any bit of the vector is set. All outputs are registered, so they appear one clock after the event that causes them. Address decode, data movement and arbitration belong to the surrounding engine and are not part of this block.

Top module: `dma_cfg_err_check`

## Requirements
- R1: A size code is 3 bits wide. Codes 0 to 5 select 1, 2, 4, 8, 16 and 32 bytes. Codes 6 and 7 are reserved, and a reserved code on one side sets both the address flag and the offset flag of that side.
- R2: On activation (`chan_act` high), bit 24 of `err_status` is set when `src_addr` is not a multiple of the source size.
- R3: On activation, bit 25 is set when the signed `src_off` is not a multiple of the source size.
- R4: On activation, bit 26 and bit 27 check `dst_addr` and the signed `dst_off` against the destination size, using the same rules as R2 and R3.
- R5: On activation, bit 28 is set in any of these cases:
  - `minor_bytes` is zero.
  - `minor_bytes` is not a multiple of the larger of the two sizes. A reserved side counts as 1 byte here.
  - `cur_iter` is zero.
  - `link_en` is low and `cur_iter` differs from `beg_iter`.
- R6: Bit 29 is set only in a cycle with `major_done` and `sg_en` both high, and only when bits [4:0] of `sg_addr` are not all zero. The value of `sg_addr` has no effect in any other cycle.
- R7: On activation, bit 17 is set when any two of the 16 four-bit priority fields in `prio_flat` are equal. Channel i's priority is bits [4i+3:4i].
- R8: Bit 30 records `src_bus_err`, and bit 31 records `dst_bus_err`, in any cycle.
- R9: The status word changes only when the current cycle has at least one error. It then becomes the new flags, with `act_ch` in bits [23:18] and zeros in bits [16:0], so every earlier flag is cleared.
- R10: Every error raises `abort` for exactly the next cycle and sets `ch_err[act_ch]`.
- R11: A one in `err_clr[i]` clears `ch_err[i]`, unless the same cycle sets that bit again. `err_valid` is the OR of `ch_err`.
- R12: While `rst_n` is low at a clock edge, all outputs go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_act | input | 1 | Channel activation strobe; triggers the descriptor checks |
| act_ch | input | 4 | Number of the active channel |
| src_addr | input | 32 | Source address |
| dst_addr | input | 32 | Destination address |
| src_off | input | 16 | Signed source offset |
| dst_off | input | 16 | Signed destination offset |
| src_size | input | 3 | Source size code |
| dst_size | input | 3 | Destination size code |
| minor_bytes | input | 32 | Minor loop byte count |
| cur_iter | input | 15 | Current iteration count |
| beg_iter | input | 15 | Beginning iteration count |
| link_en | input | 1 | Channel linking on |
| sg_addr | input | 32 | Scatter/gather descriptor address |
| sg_en | input | 1 | Scatter/gather enabled |
| major_done | input | 1 | Major loop completes this cycle |
| prio_flat | input | 64 | Sixteen 4-bit channel priorities |
| src_bus_err | input | 1 | Bus error on a source read |
| dst_bus_err | input | 1 | Bus error on a destination write |
| err_clr | input | 16 | Write-one-to-clear for ch_err |
| err_status | output | 32 | Latest error word |
| ch_err | output | 16 | Per-channel error flags |
| abort | output | 1 | One-cycle abort for the active channel |
| err_valid | output | 1 | Some channel error flag is set |

## Verification
The hardest condition to reach from the ports is a cycle in which a channel bit is set and cleared at the same time. To get there, the bench must first make an error on one channel, then make a second error on that same channel while `err_clr` for it is high. The bench therefore arranges a sequence of errors so that it controls which bits of `ch_err` are already set before it drives that cycle. The scatter/gather check is also hard to reach, because it is gated. The bench sweeps a misaligned `sg_addr` under all four combinations of `major_done` and `sg_en`, and only one combination may record an error. The duplicate-priority check needs one collision placed in each of the 120 channel pairs, and the bench steps through every pair.

// File: rtl/dma_cfg_err_pkg.sv
// Package dma_cfg_err_pkg
// What: shared field positions, the error flag struct and the size decode for the checker.
// Assumes: at most 32-byte transfers, so six low address bits are enough for alignment.
package dma_cfg_err_pkg;

    localparam int STAT_W     = 32;
    localparam int PRIO_BIT   = 17;
    localparam int CHF_LO     = 18;
    localparam int CHF_W      = 6;
    localparam int FLAG_LO    = 24;
    localparam int LOW_BITS   = 6;
    localparam int SG_ALIGN_W = 5;

    // Flags in status bits [31:24], MSB first
    typedef struct packed {
        logic wr_bus;
        logic rd_bus;
        logic sg_bad;
        logic cnt_bad;
        logic dst_off_bad;
        logic dst_adr_bad;
        logic src_off_bad;
        logic src_adr_bad;
    } err_flags_t;

    // Byte-count minus one for a size code; reserved codes give 0
    function automatic logic [LOW_BITS-1:0] size_mask(input logic [2:0] code);
        case (code)
            3'd0:    size_mask = 6'd0;
            3'd1:    size_mask = 6'd1;
            3'd2:    size_mask = 6'd3;
            3'd3:    size_mask = 6'd7;
            3'd4:    size_mask = 6'd15;
            3'd5:    size_mask = 6'd31;
            default: size_mask = 6'd0;
        endcase
    endfunction

    // True for the two reserved codes
    function automatic logic size_rsvd(input logic [2:0] code);
        size_rsvd = (code > 3'd5);
    endfunction

endpackage

// File: rtl/dma_align_chk.sv
// Module dma_align_chk
// What: checks one side (source or destination). It flags an address or offset that is not
//       a multiple of the size selected by the code, and flags a reserved code on both.
// Assumes: sizes are powers of two up to 32 bytes; the offset is two's complement.
module dma_align_chk
    import dma_cfg_err_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [OFF_W-1:0]    off,
    input  logic [2:0]          code,
    output logic                addr_bad,
    output logic                off_bad,
    output logic [LOW_BITS-1:0] mask
);
    logic rsvd;
    logic unused_hi;

    // Decode the code and test the low bits against the size
    always_comb begin
        mask      = size_mask(code);
        rsvd      = size_rsvd(code);
        addr_bad  = rsvd | (|(addr[LOW_BITS-1:0] & mask));
        off_bad   = rsvd | (|(off[LOW_BITS-1:0] & mask));
        unused_hi = ^{addr[ADDR_W-1:LOW_BITS], off[OFF_W-1:LOW_BITS]};
    end
endmodule

// File: rtl/dma_prio_uniq.sv
// Module dma_prio_uniq
// What: compares every pair of channel priority fields and reports any pair that is equal.
// Assumes: the fields are packed with channel 0 in the lowest bits.
module dma_prio_uniq #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4
) (
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic                     dup
);
    logic [NUM_CH-1:0] row_dup;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_row
        logic [NUM_CH-1:0] hit;
        for (genvar gj = 0; gj < NUM_CH; gj++) begin : g_col
            if (gj > gi) begin : g_cmp
                assign hit[gj] = (prio_flat[gi*PRIO_W +: PRIO_W] == prio_flat[gj*PRIO_W +: PRIO_W]);
            end else begin : g_none
                assign hit[gj] = 1'b0;
            end
        end
        assign row_dup[gi] = |hit;
    end

    // Any row reporting a match means the priorities are not unique
    assign dup = |row_dup;
endmodule

// File: rtl/dma_err_rec.sv
// Module dma_err_rec
// What: keeps the last-error word, the per-channel sticky flags and the abort pulse.
// Assumes: flags arrive already gated to the cycle in which they apply.
module dma_err_rec
    import dma_cfg_err_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int CH_IDX_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  err_flags_t          flags,
    input  logic                prio_bad,
    input  logic [CH_IDX_W-1:0] act_ch,
    input  logic [NUM_CH-1:0]   err_clr,
    output logic [STAT_W-1:0]   status,
    output logic [NUM_CH-1:0]   ch_err,
    output logic                abort
);
    logic              any_err;
    logic [NUM_CH-1:0] ch_hit;

    // Collapse the flags and build the one-hot channel bit
    always_comb begin
        any_err = (|flags) | prio_bad;
        ch_hit  = any_err ? ({{(NUM_CH-1){1'b0}}, 1'b1} << act_ch) : '0;
    end

    // Replace the status word on an error, otherwise hold it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (any_err) begin
            status <= {flags, CHF_W'(act_ch), prio_bad, {PRIO_BIT{1'b0}}};
        end
    end

    // Sticky per-channel flags: set wins over clear; abort lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_err <= '0;
            abort  <= 1'b0;
        end else begin
            ch_err <= (ch_err & ~err_clr) | ch_hit;
            abort  <= any_err;
        end
    end
endmodule

// File: rtl/dma_cfg_err_check.sv
// Module dma_cfg_err_check (top)
// What: checks the descriptor on channel activation, checks the scatter/gather address
//       when a major loop completes, records bus errors, and keeps the latest error.
// Assumes: all inputs are synchronous to clk; act_ch is valid whenever a strobe is high.
module dma_cfg_err_check
    import dma_cfg_err_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int NB_W   = 32,
    parameter int ITER_W = 15,
    localparam int CH_IDX_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chan_act,
    input  logic [CH_IDX_W-1:0]      act_ch,
    input  logic [ADDR_W-1:0]        src_addr,
    input  logic [ADDR_W-1:0]        dst_addr,
    input  logic [OFF_W-1:0]         src_off,
    input  logic [OFF_W-1:0]         dst_off,
    input  logic [2:0]               src_size,
    input  logic [2:0]               dst_size,
    input  logic [NB_W-1:0]          minor_bytes,
    input  logic [ITER_W-1:0]        cur_iter,
    input  logic [ITER_W-1:0]        beg_iter,
    input  logic                     link_en,
    input  logic [ADDR_W-1:0]        sg_addr,
    input  logic                     sg_en,
    input  logic                     major_done,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    input  logic                     src_bus_err,
    input  logic                     dst_bus_err,
    input  logic [NUM_CH-1:0]        err_clr,
    output logic [STAT_W-1:0]        err_status,
    output logic [NUM_CH-1:0]        ch_err,
    output logic                     abort,
    output logic                     err_valid
);
    logic                s_adr_bad, s_off_bad, d_adr_bad, d_off_bad, prio_dup;
    logic [LOW_BITS-1:0] s_mask, d_mask, big_mask;
    logic                cnt_bad;
    logic                unused_sg;
    err_flags_t          flags;

    dma_align_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_src_chk (
        .addr(src_addr), .off(src_off), .code(src_size),
        .addr_bad(s_adr_bad), .off_bad(s_off_bad), .mask(s_mask)
    );

    dma_align_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dst_chk (
        .addr(dst_addr), .off(dst_off), .code(dst_size),
        .addr_bad(d_adr_bad), .off_bad(d_off_bad), .mask(d_mask)
    );

    dma_prio_uniq #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_prio (
        .prio_flat(prio_flat), .dup(prio_dup)
    );

    // Byte count and iteration count validity, using the larger size
    always_comb begin
        big_mask = (s_mask > d_mask) ? s_mask : d_mask;
        cnt_bad  = (minor_bytes == '0)
                 | (|(minor_bytes[LOW_BITS-1:0] & big_mask))
                 | (cur_iter == '0)
                 | (!link_en && (cur_iter != beg_iter));
    end

    // Gate each check to its triggering event
    always_comb begin
        flags.src_adr_bad = chan_act & s_adr_bad;
        flags.src_off_bad = chan_act & s_off_bad;
        flags.dst_adr_bad = chan_act & d_adr_bad;
        flags.dst_off_bad = chan_act & d_off_bad;
        flags.cnt_bad     = chan_act & cnt_bad;
        flags.sg_bad      = major_done & sg_en & (|sg_addr[SG_ALIGN_W-1:0]);
        flags.rd_bus      = src_bus_err;
        flags.wr_bus      = dst_bus_err;
        unused_sg         = ^sg_addr[ADDR_W-1:SG_ALIGN_W];
    end

    dma_err_rec #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_rec (
        .clk(clk), .rst_n(rst_n), .flags(flags), .prio_bad(chan_act & prio_dup),
        .act_ch(act_ch), .err_clr(err_clr),
        .status(err_status), .ch_err(ch_err), .abort(abort)
    );

    // Summary output
    assign err_valid = |ch_err;
endmodule

// File: rtl/dma_cfg_err_check_sva.sv
// Module dma_cfg_err_check_sva
// What: temporal checks on the error checker's ports; attached to the top with bind.
// Assumes: reset is held for at least two clock edges.
module dma_cfg_err_check_sva #(
    parameter int NUM_CH   = 16,
    parameter int CH_IDX_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CH_IDX_W-1:0] act_ch,
    input logic                major_done,
    input logic                sg_en,
    input logic                src_bus_err,
    input logic                dst_bus_err,
    input logic [31:0]         err_status,
    input logic [NUM_CH-1:0]   ch_err,
    input logic                abort,
    input logic                err_valid
);
    // R9: without an error the status word holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !abort |-> $stable(err_status));

    // R9: the channel field carries the channel active at the error
    p_chan_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (err_status[18 +: CH_IDX_W] == $past(act_ch)));

    // R6: a scatter/gather error needs major loop completion with scatter/gather enabled
    p_sg_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && err_status[29]) |-> $past(major_done && sg_en));

    // R8: bus errors are always recorded
    p_src_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_bus_err |=> (abort && err_status[30]));

    p_dst_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dst_bus_err |=> (abort && err_status[31]));

    // R10: abort marks the failing channel in the sticky vector
    p_ch_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> ch_err[err_status[18 +: CH_IDX_W]]);

    // R11: the summary follows an abort
    p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> err_valid);
endmodule

bind dma_cfg_err_check dma_cfg_err_check_sva #(.NUM_CH(NUM_CH), .CH_IDX_W($clog2(NUM_CH))) u_sva (
    .clk(clk), .rst_n(rst_n), .act_ch(act_ch), .major_done(major_done), .sg_en(sg_en),
    .src_bus_err(src_bus_err), .dst_bus_err(dst_bus_err), .err_status(err_status),
    .ch_err(ch_err), .abort(abort), .err_valid(err_valid)
);

// File: tb/sim_dma_cfg_err_check.sv
// Bench sim_dma_cfg_err_check: sweeps of the checker, with expected words computed arithmetically.
module sim_dma_cfg_err_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_act = 1'b0;
    logic [3:0]  act_ch = '0;
    logic [31:0] src_addr = '0, dst_addr = '0, sg_addr = '0, minor_bytes = 32'd64;
    logic [15:0] src_off = '0, dst_off = '0;
    logic [2:0]  src_size = '0, dst_size = '0;
    logic [14:0] cur_iter = 15'd1, beg_iter = 15'd1;
    logic        link_en = 1'b0, sg_en = 1'b0, major_done = 1'b0;
    logic [63:0] prio_flat;
    logic        src_bus_err = 1'b0, dst_bus_err = 1'b0;
    logic [15:0] err_clr = '0;
    logic [31:0] err_status;
    logic [15:0] ch_err;
    logic        abort, err_valid;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_stat = '0;
    logic [15:0] exp_ch = '0;

    always #10 clk = ~clk;

    dma_cfg_err_check u0 (
        .clk(clk), .rst_n(rst_n), .chan_act(chan_act), .act_ch(act_ch),
        .src_addr(src_addr), .dst_addr(dst_addr), .src_off(src_off), .dst_off(dst_off),
        .src_size(src_size), .dst_size(dst_size), .minor_bytes(minor_bytes),
        .cur_iter(cur_iter), .beg_iter(beg_iter), .link_en(link_en), .sg_addr(sg_addr),
        .sg_en(sg_en), .major_done(major_done), .prio_flat(prio_flat),
        .src_bus_err(src_bus_err), .dst_bus_err(dst_bus_err), .err_clr(err_clr),
        .err_status(err_status), .ch_err(ch_err), .abort(abort), .err_valid(err_valid)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic int nbytes(input int code);
        return (code < 6) ? (1 << code) : 0;
    endfunction

    function automatic bit side_adr_bad(input int code, input longint a);
        int b = nbytes(code);
        return (b == 0) || ((a % b) != 0);
    endfunction

    // Default descriptor: valid on both sides; unique priorities
    task automatic base();
        src_addr = '0; dst_addr = '0; src_off = '0; dst_off = '0;
        src_size = '0; dst_size = '0; minor_bytes = 32'd64;
        cur_iter = 15'd1; beg_iter = 15'd1; link_en = 1'b0;
        sg_addr = '0; sg_en = 1'b0; major_done = 1'b0;
        for (int i = 0; i < 16; i++) prio_flat[i*4 +: 4] = 4'(i);
    endtask

    // Compute expectations from current inputs, cross one clock edge, compare
    task automatic step(input string req);
        bit [7:0] f;
        bit pr, any;
        int bs, bd, mx;
        bit dupf;
        f = '0;
        dupf = 1'b0;
        for (int i = 0; i < 16; i++)
            for (int j = i + 1; j < 16; j++)
                if (prio_flat[i*4 +: 4] == prio_flat[j*4 +: 4]) dupf = 1'b1;
        if (chan_act) begin
            f[0] = side_adr_bad(int'(src_size), longint'(src_addr));
            f[1] = side_adr_bad(int'(src_size), longint'(int'($signed(src_off))));
            f[2] = side_adr_bad(int'(dst_size), longint'(dst_addr));
            f[3] = side_adr_bad(int'(dst_size), longint'(int'($signed(dst_off))));
            bs = nbytes(int'(src_size)); if (bs == 0) bs = 1;
            bd = nbytes(int'(dst_size)); if (bd == 0) bd = 1;
            mx = (bs > bd) ? bs : bd;
            f[4] = (minor_bytes == 0) || ((longint'(minor_bytes) % mx) != 0)
                || (cur_iter == 0) || (!link_en && cur_iter != beg_iter);
        end
        f[5] = major_done && sg_en && ((sg_addr % 32) != 0);
        f[6] = src_bus_err;
        f[7] = dst_bus_err;
        pr  = chan_act && dupf;
        any = (f != 0) || pr;
        if (any) exp_stat = {f, 2'b00, act_ch, pr, 17'd0};
        exp_ch = (exp_ch & ~err_clr) | (any ? (16'd1 << act_ch) : 16'd0);
        @(negedge clk);
        chk(req, err_status, exp_stat);
        chk({req, "/R10"}, {15'd0, abort, ch_err}, {15'd0, any, exp_ch});
        chk("R11", {31'd0, err_valid}, {31'd0, |exp_ch});
        chan_act = 1'b0; major_done = 1'b0; src_bus_err = 1'b0; dst_bus_err = 1'b0;
        err_clr = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        base();
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", err_status, 32'd0);
        chk("R12", {14'd0, abort, err_valid, ch_err}, 32'd0);
        rst_n = 1'b1;

        // R1 R2 R3: source size codes against addresses and offsets
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 64; a++) begin
                base(); src_size = 3'(s); src_addr = 32'(a);
                chan_act = 1'b1; act_ch = 4'(a % 16); step("R2");
            end
            for (int o = -40; o <= 40; o++) begin
                base(); src_size = 3'(s); src_off = 16'(o);
                chan_act = 1'b1; act_ch = 4'((o + 40) % 16); step("R3");
            end
        end
        // R1 R4: destination side
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 64; a++) begin
                base(); dst_size = 3'(s); dst_addr = 32'(a) + 32'h1000_0000;
                chan_act = 1'b1; act_ch = 4'(a % 16); step("R4");
            end
            for (int o = -40; o <= 40; o++) begin
                base(); dst_size = 3'(s); dst_off = 16'(o);
                chan_act = 1'b1; act_ch = 4'(s + 3); step("R4");
            end
        end
        // R5: byte counts and iteration counts
        for (int s = 0; s < 8; s++)
            for (int n = 0; n < 70; n++) begin
                base(); src_size = 3'(s); dst_size = 3'(7 - s); minor_bytes = 32'(n);
                src_size = (s > 5) ? 3'(s) : src_size;
                src_addr = '0; chan_act = 1'b1; act_ch = 4'(n % 16); step("R5");
            end
        for (int c = 0; c < 4; c++)
            for (int b = 0; b < 4; b++)
                for (int l = 0; l < 2; l++) begin
                    base(); cur_iter = 15'(c); beg_iter = 15'(b); link_en = l[0];
                    chan_act = 1'b1; act_ch = 4'(c * 4 + b); step("R5");
                end
        // R6: scatter/gather check gated by loop completion and enable
        for (int g = 0; g < 4; g++)
            for (int a = 0; a < 64; a++) begin
                base(); sg_addr = 32'(a * 3); major_done = g[0]; sg_en = g[1];
                act_ch = 4'(a % 16); step("R6");
            end
        // R7: each pair of equal priorities
        for (int i = 0; i < 16; i++)
            for (int j = i + 1; j < 16; j++) begin
                base(); prio_flat[j*4 +: 4] = 4'(i);
                chan_act = 1'b1; act_ch = 4'(j); step("R7");
            end
        base(); prio_flat[15*4 +: 4] = 4'd14; step("R7");  // no activation: ignored
        // R8: bus error strobes
        for (int k = 1; k < 4; k++) begin
            base(); src_bus_err = k[0]; dst_bus_err = k[1]; act_ch = 4'(k + 8); step("R8");
        end
        // R9: valid activation holds the word; a new error replaces it
        base(); chan_act = 1'b1; act_ch = 4'd2; step("R9");
        base(); src_bus_err = 1'b1; src_addr = 32'd1; src_size = 3'd2; chan_act = 1'b1;
        act_ch = 4'd5; step("R9");
        base(); dst_bus_err = 1'b1; act_ch = 4'd6; step("R9");
        // R11: clear every channel, then set-versus-clear in one cycle
        for (int i = 0; i < 16; i++) begin
            base(); err_clr = 16'd1 << i; act_ch = 4'((i + 1) % 16); step("R11");
        end
        base(); src_bus_err = 1'b1; act_ch = 4'd7; step("R11");
        base(); src_bus_err = 1'b1; act_ch = 4'd7; err_clr = 16'hFFFF; step("R11");
        base(); err_clr = 16'h0080; step("R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule